// File: doc/BRIEF.md
# Formula-Encoded History Branch Predictor

This block predicts the direction of a conditional branch without any table of counters. Each branch carries a small encoding word chosen ahead of time. The word configures a balanced binary tree of two-input gates, and each gate acts as either AND or OR. The leaves of the tree are the bits of a global branch-history shift register. Every history bit feeds exactly one leaf, uninverted. The tree's single output, optionally inverted by the top encoding bit, is the taken/not-taken guess.

The front end raises the predict strobe together with the encoding word and reads the prediction in that same cycle, because the whole evaluation is combinational. When a branch resolves, the back end presents the real outcome on the resolve port. The history then shifts by one place. Resolves are expected in program order. The history width is a parameter, with 8 as the default and 16 as the wider option. The encoding word has the same width as the history.

Top module: `bfp_predictor`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every history bit to 0. After reset, the all-OR encoding therefore predicts not-taken.
- R2: pred_valid_o equals pred_req_i in the same cycle. While pred_req_i is low, pred_taken_o is 0.
- R3: Gates are numbered in heap order. Gate 0 is the root, and gate g has children 2g+1 and 2g+2. Encoding bit g sets the type of gate g: 0 means AND and 1 means OR. Leaf gate k, which is gate number HIST_W/2-1+k, combines history bits 2k and 2k+1.
- R4: With a predict strobe, pred_taken_o is the tree result produced in that same cycle, with no register in the path.
- R5: An encoding whose gate bits are all 0 predicts the AND of all history bits. An encoding whose gate bits are all 1 predicts the OR of all history bits.
- R6: Encoding bit HIST_W-1 (bit 7 in the 8-bit case) inverts the tree result when it is 1.
- R7: On a clock edge with resolve_i high, the history shifts one place toward its MSB. outcome_i enters bit 0, and the old MSB is discarded.
- R8: On a clock edge with resolve_i low, the history keeps its value, whatever the predict inputs do.
- R9: When predict and resolve are both high in one cycle, the prediction is formed from the history as it was before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_req_i | input | 1 | Predict strobe |
| formula_i | input | HIST_W | Encoding word: gate types plus the inversion bit |
| resolve_i | input | 1 | Resolve strobe |
| outcome_i | input | 1 | Actual direction of the resolved branch (1 = taken) |
| pred_taken_o | output | 1 | Predicted direction (1 = taken) |
| pred_valid_o | output | 1 | Prediction valid this cycle |

## Verification
The bound checker watches the history register on every cycle. It confirms the clear on reset, the one-place shift with the new outcome in bit 0, and that the history holds when no resolve arrives. It also confirms that the all-AND and all-OR encodings always track the AND and OR of the live history, and that the outputs stay quiet without a strobe. Only the bench scenarios can show that each of the 256 encodings evaluates to the heap-ordered tree with the correct leaf pairing and inversion. The bench runs those encodings against a recursive model over random histories. Only the bench can also show the pre-update history being used when predict and resolve coincide.

// File: rtl/bfp_pkg.sv
// Package: shared types for the formula-encoded branch predictor.
// Assumes the encoding convention 0 = AND gate, 1 = OR gate.
package bfp_pkg;

    typedef enum logic {
        GATE_AND = 1'b0,
        GATE_OR  = 1'b1
    } gate_kind_e;

endpackage

// File: rtl/bfp_gate.sv
// Module: one configurable two-input gate of the formula tree.
// Assumes the kind input is static for the cycle; purely combinational.
module bfp_gate
    import bfp_pkg::*;
(
    input  gate_kind_e kind,
    input  logic       a,
    input  logic       b,
    output logic       y
);

    // Select AND or OR of the two inputs.
    always_comb begin
        if (kind == GATE_OR) y = a | b;
        else                 y = a & b;
    end

endmodule

// File: rtl/bfp_tree.sv
// Module: balanced monotone read-once AND/OR tree over the history bits.
// Assumes HIST_W is a power of two, at least 2. Gates are in heap order:
// gate 0 is the root, and level l holds gates 2**l-1 .. 2**(l+1)-2 from left
// to right. Leaf gate k combines history bits 2k and 2k+1.
module bfp_tree
    import bfp_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [HIST_W-2:0] cfg,
    output logic              y
);

    localparam int LEVELS = $clog2(HIST_W);

    // lvl[l] holds the 2**l node values of level l; lvl[LEVELS] is the history.
    logic [HIST_W-1:0] lvl [LEVELS+1];

    // Leaf row: the history feeds the bottom of the tree.
    always_comb lvl[LEVELS] = hist;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int NODES = 1 << l;
        localparam int BASE  = NODES - 1;
        logic [NODES-1:0] outs;
        for (genvar j = 0; j < NODES; j++) begin : g_node
            bfp_gate u_gate (
                .kind (gate_kind_e'(cfg[BASE+j])),
                .a    (lvl[l+1][2*j]),
                .b    (lvl[l+1][2*j+1]),
                .y    (outs[j])
            );
        end
        if (NODES < HIST_W) begin : g_pad
            // Pad the unused upper part of this row with zeros.
            always_comb lvl[l] = {{(HIST_W-NODES){1'b0}}, outs};
        end else begin : g_full
            // Full-width row: no padding needed.
            always_comb lvl[l] = outs;
        end
    end

    // The root node is the formula result.
    always_comb y = lvl[0][0];

endmodule

// File: rtl/bfp_history.sv
// Module: global branch-history shift register.
// Assumes resolves arrive in program order. Bit 0 holds the newest outcome.
module bfp_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_o
);

    // Clear on reset; on a resolve, shift toward the MSB and insert the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist_o <= '0;
        else if (shift_en) hist_o <= {hist_o[HIST_W-2:0], bit_in};
    end

endmodule

// File: rtl/bfp_predictor.sv
// Module: top of the formula-encoded history branch predictor.
// Assumes formula_i is valid whenever pred_req_i is high. The prediction is
// combinational from the current history and the encoding word. Encoding bits
// HIST_W-2..0 set the gate types, and bit HIST_W-1 inverts the result.
module bfp_predictor #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_req_i,
    input  logic [HIST_W-1:0] formula_i,
    input  logic              resolve_i,
    input  logic              outcome_i,
    output logic              pred_taken_o,
    output logic              pred_valid_o
);

    localparam int GATES = HIST_W - 1;
    localparam int INV_BIT = HIST_W - 1;

    logic [HIST_W-1:0] hist_q;
    logic              tree_y;

    bfp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (resolve_i),
        .bit_in   (outcome_i),
        .hist_o   (hist_q)
    );

    bfp_tree #(.HIST_W(HIST_W)) u_tree (
        .hist (hist_q),
        .cfg  (formula_i[GATES-1:0]),
        .y    (tree_y)
    );

    // Apply the optional inversion and gate the result with the strobe.
    always_comb begin
        pred_valid_o = pred_req_i;
        pred_taken_o = pred_req_i & (tree_y ^ formula_i[INV_BIT]);
    end

endmodule

// File: rtl/bfp_predictor_chk.sv
// Module: assertion checker bound to bfp_predictor.
// Assumes it can see the internal history through the bind connection.
module bfp_predictor_chk #(
    parameter int HIST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_req_i,
    input logic [HIST_W-1:0] formula_i,
    input logic              resolve_i,
    input logic              outcome_i,
    input logic              pred_taken_o,
    input logic              pred_valid_o,
    input logic [HIST_W-1:0] hist
);

    localparam logic [HIST_W-1:0] ENC_ALL_AND = '0;
    localparam logic [HIST_W-1:0] ENC_ALL_OR  = {1'b0, {(HIST_W-1){1'b1}}};

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> hist == '0);

    a_r7_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_i |=> hist == {$past(hist[HIST_W-2:0]), $past(outcome_i)});

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !resolve_i |=> $stable(hist));

    a_r5_all_and: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_req_i && formula_i == ENC_ALL_AND) |-> pred_taken_o == (&hist));

    a_r5_all_or: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_req_i && formula_i == ENC_ALL_OR) |-> pred_taken_o == (|hist));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_req_i |-> (!pred_valid_o && !pred_taken_o));

endmodule

bind bfp_predictor bfp_predictor_chk #(.HIST_W(HIST_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pred_req_i   (pred_req_i),
    .formula_i    (formula_i),
    .resolve_i    (resolve_i),
    .outcome_i    (outcome_i),
    .pred_taken_o (pred_taken_o),
    .pred_valid_o (pred_valid_o),
    .hist         (hist_q)
);

// File: tb/bfp_predictor_bench.sv
// Bench: self-checking testbench for bfp_predictor with the default 8-bit history.
module bfp_predictor_bench;

    localparam int W = 8;
    localparam int NVEC = 12;
    localparam logic [W-1:0] F_AND = 8'h00;
    localparam logic [W-1:0] F_OR  = 8'h7F;

    // Each entry is {history, encoding, expected prediction}, worked out by hand.
    localparam logic [16:0] VEC [NVEC] = '{
        {8'hFF, 8'h00, 1'b1},   // R5 all AND, all ones
        {8'hFE, 8'h00, 1'b0},   // R5 all AND, one zero
        {8'h01, 8'h7F, 1'b1},   // R5 all OR, one bit
        {8'h00, 8'h7F, 1'b0},   // R5 all OR, empty
        {8'h00, 8'h80, 1'b1},   // R6 inverted all AND
        {8'hF0, 8'h01, 1'b1},   // R3 root OR of two AND halves
        {8'hE7, 8'h01, 1'b0},   // R3 neither half all ones
        {8'h55, 8'h78, 1'b1},   // R3 leaf OR pairs 2k,2k+1 all hit
        {8'h0F, 8'h78, 1'b0},   // R3 pair bits 4,5 empty
        {8'hC3, 8'h06, 1'b1},   // R3 level-1 OR gates
        {8'h99, 8'h06, 1'b0},   // R3 no AND pair complete
        {8'hC3, 8'h86, 1'b0}    // R6 inversion of the level-1 case
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pred_req_i = 1'b0;
    logic [W-1:0] formula_i = '0;
    logic         resolve_i = 1'b0;
    logic         outcome_i = 1'b0;
    logic         pred_taken_o;
    logic         pred_valid_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] hist_m = '0;

    always #5 clk = ~clk;

    bfp_predictor #(.HIST_W(W)) u_bfp_predictor (
        .clk          (clk),
        .rst_n        (rst_n),
        .pred_req_i   (pred_req_i),
        .formula_i    (formula_i),
        .resolve_i    (resolve_i),
        .outcome_i    (outcome_i),
        .pred_taken_o (pred_taken_o),
        .pred_valid_o (pred_valid_o)
    );

    // Recursive reference: node g < W-1 is a gate, otherwise a history leaf.
    function automatic logic ref_node(int g, logic [W-1:0] h, logic [W-1:0] f);
        logic a, b;
        if (g >= W - 1) return h[g-(W-1)];
        a = ref_node(2*g+1, h, f);
        b = ref_node(2*g+2, h, f);
        return f[g] ? (a | b) : (a & b);
    endfunction

    function automatic logic ref_pred(logic [W-1:0] h, logic [W-1:0] f);
        return ref_node(0, h, f) ^ f[W-1];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Shift one outcome in on the next edge, and track it in the model.
    task automatic push(input logic o);
        @(negedge clk);
        resolve_i = 1'b1;
        outcome_i = o;
        @(negedge clk);
        resolve_i = 1'b0;
        hist_m = {hist_m[W-2:0], o};
    endtask

    // Load a whole history, MSB first.
    task automatic load_hist(input logic [W-1:0] h);
        for (int i = W - 1; i >= 0; i--) push(h[i]);
    endtask

    // Present a strobe with an encoding and sample before the next edge.
    task automatic predict(input logic [W-1:0] f);
        @(negedge clk);
        pred_req_i = 1'b1;
        formula_i = f;
        #1;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: history is empty after reset.
        predict(F_OR);
        chk("R1 reset history", pred_taken_o, 1'b0);
        pred_req_i = 1'b0;
        load_hist(8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        hist_m = '0;
        predict(F_OR);
        chk("R1 reset after load", pred_taken_o, 1'b0);

        // R2: valid follows the strobe, and the prediction is quiet when idle.
        pred_req_i = 1'b0;
        load_hist(8'hFF);
        @(negedge clk);
        formula_i = F_AND;
        #1;
        chk("R2 valid low when idle", pred_valid_o, 1'b0);
        chk("R2 taken low when idle", pred_taken_o, 1'b0);
        predict(F_AND);
        chk("R2 valid with strobe", pred_valid_o, 1'b1);

        // R3 R5 R6: walk the vector table.
        for (int v = 0; v < NVEC; v++) begin
            pred_req_i = 1'b0;
            load_hist(VEC[v][16:9]);
            predict(VEC[v][8:1]);
            chk($sformatf("R3/R5/R6 vector %0d", v), pred_taken_o, VEC[v][0]);
        end

        // R3 R4 R6: sweep every encoding over random histories (same-cycle result).
        for (int r = 0; r < 12; r++) begin
            pred_req_i = 1'b0;
            load_hist(W'($urandom));
            for (int f = 0; f < 256; f++) begin
                predict(W'(f));
                chk($sformatf("R4 sweep h=%h f=%h", hist_m, f[7:0]),
                    pred_taken_o, ref_pred(hist_m, W'(f)));
            end
        end

        // R7: the oldest bit drops out and the new outcome enters bit 0.
        pred_req_i = 1'b0;
        load_hist(8'h80);
        push(1'b0);
        predict(F_OR);
        chk("R7 MSB discarded", pred_taken_o, 1'b0);
        pred_req_i = 1'b0;
        push(1'b1);
        predict(8'h78);
        chk("R7 outcome in bit 0", pred_taken_o, 1'b0);
        predict(F_OR);
        chk("R7 outcome in bit 0 seen", pred_taken_o, 1'b1);

        // R8: the history holds over strobes when no resolve is raised.
        pred_req_i = 1'b0;
        load_hist(8'hFF);
        for (int c = 0; c < 5; c++) begin
            predict(W'(c * 37));
            outcome_i = 1'b0;
        end
        predict(F_AND);
        chk("R8 history held", pred_taken_o, 1'b1);

        // R9: predict and resolve together use the history from before the update.
        pred_req_i = 1'b0;
        load_hist(8'h00);
        @(negedge clk);
        pred_req_i = 1'b1;
        formula_i = F_OR;
        resolve_i = 1'b1;
        outcome_i = 1'b1;
        #1;
        chk("R9 pre-update history", pred_taken_o, 1'b0);
        @(negedge clk);
        resolve_i = 1'b0;
        #1;
        chk("R9 update visible next cycle", pred_taken_o, 1'b1);
        pred_req_i = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule